// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block sits between a 16-bit microprocessor bus and four devices: a program ROM, a data RAM, a sensor input port and an alarm output latch. It decodes the address and the read and write strobes into active-low chip selects. It also contains small models of each device, so the bus reads back a registered data byte from whichever device the cycle selected.

The sensor and alarm windows share the address 0xFFFE. Bus direction settles the overlap: the sensor port answers only reads and the alarm latch accepts only writes, so at most one select is ever low. Any address outside the four windows selects nothing. A read from such an address returns zero and raises a one-cycle flag.

Top module: `bus_addr_decoder`

## Requirements
- R1: The ROM select is low for addresses 0x0000–0x1FFF whenever either strobe is high. A ROM read returns the byte A[7:0] ^ {3'b000, A[12:8]} ^ 0x5A.
- R2: The RAM select is low for addresses 0x2000–0x3FFF (A15..A13 = 001) whenever either strobe is high. Writes store wdata and reads return it. The array holds 2^RAM_AW bytes, indexed by A[RAM_AW-1:0], and aliases through the rest of the window.
- R3: The sensor select is low for 0xFFF0–0xFFFF on reads only. A read returns the sensor inputs after they pass two synchronising flops. A change on the inputs therefore shows up in read data for a read strobe asserted two or more cycles after the change, and not before.
- R4: The alarm select is low only at 0xFFFE, and only on writes. On that clock edge alarm_out loads wdata, and it holds its value until the next such write.
- R5: All selects are active low. At most one is low in any cycle, and all are high when no strobe is high. A cycle with both strobes high counts as a write.
- R6: Addresses 0x4000–0xFFEF assert no select. A read there returns 0x00 and sets unmapped high for the one cycle after the strobe.
- R7: Writes to the ROM window, the sensor window outside 0xFFFE, or unmapped addresses change neither the RAM contents nor alarm_out.
- R8: rdata and unmapped are registered and valid the cycle after the read strobe. After a cycle with no read, both are zero.
- R9: A synchronous active-high reset clears rdata, unmapped, alarm_out and the synchroniser to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| sensor_in | input | DW | Asynchronous sensor inputs |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| sens_cs_n | output | 1 | Sensor port select, active low |
| alarm_cs_n | output | 1 | Alarm latch select, active low |
| rdata | output | DW | Registered read data |
| unmapped | output | 1 | One-cycle flag for an unmapped read |
| alarm_out | output | DW | Alarm latch contents |

## Verification
The selects are combinational. The bench checks them 1 ns after driving each address, within the same cycle. Read data and the unmapped flag come one clock later, and alarm_out changes on the edge that ends the write. The bench drives on the falling edge and checks each registered result at the next falling edge, with both sweeps running back to back over all 65536 addresses. The sensor test reads on three consecutive cycles after an input change, to confirm that the two-cycle synchroniser delay is neither shorter nor longer than required.

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder #(
  parameter int DW     = 8,
  parameter int RAM_AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sensor_in,
  output logic          rom_cs_n,
  output logic          ram_cs_n,
  output logic          sens_cs_n,
  output logic          alarm_cs_n,
  output logic [DW-1:0] rdata,
  output logic          unmapped,
  output logic [DW-1:0] alarm_out
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic rd_eff, rom_win, ram_win, sens_win, alarm_hit, any_win;
  logic [DW-1:0] rom_byte, sync1, sync2;
  logic [DW-1:0] mem [RAM_DEPTH];

  assign rd_eff    = rd & ~wr;
  assign rom_win   = addr[15:13] == 3'b000;
  assign ram_win   = addr[15:13] == 3'b001;
  assign sens_win  = addr[15:4] == 12'hFFF;
  assign alarm_hit = addr == 16'hFFFE;
  assign any_win   = rom_win | ram_win | sens_win;

  assign rom_cs_n   = ~(rom_win & (rd | wr));
  assign ram_cs_n   = ~(ram_win & (rd | wr));
  assign sens_cs_n  = ~(sens_win & rd_eff);
  assign alarm_cs_n = ~(alarm_hit & wr);

  assign rom_byte = DW'({3'b000, addr[12:8]} ^ addr[7:0] ^ 8'h5A);

  always_ff @(posedge clk)
    if (!ram_cs_n && wr) mem[addr[RAM_AW-1:0]] <= wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= sensor_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      unmapped <= 1'b0;
    end else if (rd_eff) begin
      unmapped <= ~any_win;
      if (rom_win)       rdata <= rom_byte;
      else if (ram_win)  rdata <= mem[addr[RAM_AW-1:0]];
      else if (sens_win) rdata <= sync2;
      else               rdata <= '0;
    end else begin
      rdata    <= '0;
      unmapped <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) alarm_out <= '0;
    else if (!alarm_cs_n) alarm_out <= wdata;
  end

  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~rom_cs_n, ~ram_cs_n, ~sens_cs_n, ~alarm_cs_n}) <= 1);

  // R4
  alarm_load_chk: assert property (@(posedge clk) disable iff (rst)
    !alarm_cs_n |=> alarm_out == $past(wdata));

  // R7
  alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_cs_n |=> $stable(alarm_out));

  // R6
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> rdata == '0);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd && !wr) |=> (!unmapped && rdata == '0));
endmodule

// File: tb/test_bus_addr_decoder.sv
module test_bus_addr_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1, rd = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, sensor_in = 8'hC3;
  logic rom_cs_n, ram_cs_n, sens_cs_n, alarm_cs_n, unmapped;
  logic [7:0] rdata, alarm_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_addr_decoder #(.DW(8), .RAM_AW(8)) i_bus_addr_decoder (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .sensor_in(sensor_in), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .sens_cs_n(sens_cs_n), .alarm_cs_n(alarm_cs_n), .rdata(rdata),
    .unmapped(unmapped), .alarm_out(alarm_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cs(logic [15:0] a, logic r, logic w);
    logic re;
    re = r & ~w;
    exp_cs[3] = ~((a[15:13] == 3'b000) & (r | w));
    exp_cs[2] = ~((a[15:13] == 3'b001) & (r | w));
    exp_cs[1] = ~((a[15:4] == 12'hFFF) & re);
    exp_cs[0] = ~((a == 16'hFFFE) & w);
  endfunction

  function automatic logic [8:0] exp_read(logic [15:0] a);
    if (a[15:13] == 3'b000) return {1'b0, a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A};
    if (a[15:13] == 3'b001) return {1'b0, a[7:0] ^ 8'h3F};
    if (a[15:4] == 12'hFFF) return {1'b0, 8'hC3};
    return {1'b1, 8'h00};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] exp_alarm;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 rdata", rdata, 0);
    chk("R9 unmapped", unmapped, 0);
    chk("R9 alarm_out", alarm_out, 0);
    rst = 1'b0;
    #1 chk("R5 idle selects", {rom_cs_n, ram_cs_n, sens_cs_n, alarm_cs_n}, 4'hF);

    exp_alarm = 8'h00;
    for (int a = 0; a < 65536; a++) begin
      @(negedge clk);
      if (a > 0) begin
        chk("R4 R7 alarm_out", alarm_out, exp_alarm);
        chk("R8 write cycle rdata", {unmapped, rdata}, 0);
      end
      addr = 16'(a); wr = 1'b1; rd = 1'b0; wdata = addr[7:0] ^ addr[15:8];
      #1 chk("R1 R2 R3 R4 R5 R6 write selects",
             {rom_cs_n, ram_cs_n, sens_cs_n, alarm_cs_n}, exp_cs(addr, 1'b0, 1'b1));
      if (addr == 16'hFFFE) exp_alarm = wdata;
    end
    @(negedge clk);
    wr = 1'b0;
    chk("R4 alarm held", alarm_out, 8'h01);

    for (int a = 0; a < 65536; a++) begin
      @(negedge clk);
      if (a > 0)
        chk("R1 R2 R3 R6 R7 R8 read data", {unmapped, rdata}, exp_read(addr));
      addr = 16'(a); rd = 1'b1;
      #1 chk("R1 R2 R3 R5 R6 read selects",
             {rom_cs_n, ram_cs_n, sens_cs_n, alarm_cs_n}, exp_cs(addr, 1'b1, 1'b0));
    end
    @(negedge clk);
    chk("R3 last read", {unmapped, rdata}, exp_read(16'hFFFF));
    rd = 1'b0;
    @(negedge clk);
    chk("R8 idle after read", {unmapped, rdata}, 0);
    chk("R6 flag one cycle", unmapped, 0);

    // R3 synchroniser latency
    sensor_in = 8'h3C; addr = 16'hFFF3; rd = 1'b1;
    @(negedge clk); chk("R3 sensor lag 0", rdata, 8'hC3);
    @(negedge clk); chk("R3 sensor lag 1", rdata, 8'hC3);
    @(negedge clk); chk("R3 sensor lag 2", rdata, 8'h3C);
    rd = 1'b0;

    // R5 both strobes at the shared address act as a write
    addr = 16'hFFFE; rd = 1'b1; wr = 1'b1; wdata = 8'h99;
    #1 chk("R5 rd+wr selects", {rom_cs_n, ram_cs_n, sens_cs_n, alarm_cs_n}, 4'b1110);
    @(negedge clk);
    chk("R4 R5 rd+wr alarm", alarm_out, 8'h99);
    chk("R5 rd+wr no read", {unmapped, rdata}, 0);
    rd = 1'b0; wr = 1'b0;

    // R7 write to sensor window outside alarm
    addr = 16'hFFF5; wr = 1'b1; wdata = 8'h11;
    #1 chk("R7 sensor write selects", {rom_cs_n, ram_cs_n, sens_cs_n, alarm_cs_n}, 4'hF);
    @(negedge clk); wr = 1'b0;
    chk("R7 alarm untouched", alarm_out, 8'h99);

    // R9 reset clears alarm
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 alarm cleared", alarm_out, 0);
    finish_run();
  end
endmodule